// File: doc/BRIEF.md
# Micro Translation Cache

This block is a ten-entry, fully associative cache of address translations. It sits between a requester (either the fetch side or the load/store side; each side gets its own copy) and a larger shared main TLB. Every cycle in which the requester presents a virtual page number, all ten entries are compared at once. On a match, the physical page number and its attribute bits come back combinationally in the same cycle.

On a miss, the block drops its ready output and raises a request to the main TLB that carries the missing page number. It holds that request until the main TLB returns a fill. The fill is written into a victim entry. The victim is chosen either by a rotating pointer or by a pseudo-random generator, and a control input selects between the two at run time. A flush input invalidates every entry in a single cycle. Attribute bits are passed through unchanged and are not interpreted.

Top module: `micro_tlb`

## Requirements
- R1: After reset, `lk_ready` is 1, `mt_req` is 0 and no entry is valid, so the first lookup of any page misses.
- R2: When `lk_valid` is 1 and the block is ready, a page that matches a valid entry raises `lk_hit` in the same cycle, with that entry's `lk_ppn` and `lk_attr`.
- R3: A lookup with `lk_valid` 1 that misses while ready causes, from the next cycle on, `mt_req`=1, `mt_vpn` equal to the missed page and `lk_ready`=0. These values hold unchanged until a fill arrives.
- R4: In a waiting cycle with `mt_fill_valid`=1, the fill data is installed together with the captured page. In the following cycle `lk_ready` is 1 and `mt_req` is 0, and a lookup of that page hits with the filled PPN and attributes.
- R5: `mt_fill_valid` has no effect while no request is outstanding: ready stays 1, no request is raised, and every cached entry keeps its contents.
- R6: With `repl_random`=0 (rotating mode), the victim is a pointer that starts at entry 0 after reset. It advances by one on each rotating-mode install and wraps from entry 9 back to entry 0. It does not move in random mode.
- R7: With `repl_random`=1, the victim index is S mod 10, where S is a 16-bit state seeded with 0xACE1 at reset. S advances only on random-mode installs. Each step shifts S right by one and, if the bit shifted out was 1, XORs the result with 0xB400. The index is always in the range 0..9.
- R8: A cycle with `flush`=1 invalidates all ten entries, so every lookup in the next cycle misses. When a flush and an install fall in the same cycle, the flush wins and nothing is written.
- R9: While `lk_valid` is 0, `lk_hit` is 0 and no main-TLB request is raised, even if the presented page is cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_ready | output | 1 | Block can accept a lookup (no miss pending) |
| lk_hit | output | 1 | Translation found this cycle |
| lk_ppn | output | 20 | Physical page number of the hit |
| lk_attr | output | 8 | Attribute bits of the hit |
| mt_req | output | 1 | Request pending to the main TLB |
| mt_vpn | output | 20 | Page number being requested |
| mt_fill_valid | input | 1 | Main TLB returns a translation |
| mt_fill_ppn | input | 20 | Returned physical page number |
| mt_fill_attr | input | 8 | Returned attribute bits |
| flush | input | 1 | Invalidate all entries |
| repl_random | input | 1 | 0 selects the rotating victim, 1 the pseudo-random victim |

## Verification
The bench runs three kinds of lookup stream. The first walks ten distinct pages and then revisits some of them. This separates true parallel matching across all ten entries from a design that loses entries, and it shows the rotating pointer wrapping by evicting exactly the oldest pages. The second stream runs in random mode over more pages than fit, checked against a bench model of the generator. It tells a correct S mod 10 victim apart from a wrong seed, wrong taps or a wrong reduction. Around these streams, directed cases apply a flush, a stray fill, a lookup with `lk_valid` low and a switch back to rotating mode. These show that the pointer kept its place and that stray inputs change nothing.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    localparam int VPN_W   = 20;
    localparam int PPN_W   = 20;
    localparam int ATTR_W  = 8;
    localparam int ENTRIES = 10;
    localparam int IDX_W   = $clog2(ENTRIES);

    localparam int              RNG_W    = 16;
    localparam logic [RNG_W-1:0] RNG_SEED = 16'hACE1;
    localparam logic [RNG_W-1:0] RNG_TAPS = 16'hB400;

    typedef enum logic { REPL_ROTATE = 1'b0, REPL_RANDOM = 1'b1 } repl_mode_e;
    typedef enum logic { ST_IDLE = 1'b0, ST_WAIT = 1'b1 } fill_state_e;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
        return s[0] ? ((s >> 1) ^ RNG_TAPS) : (s >> 1);
    endfunction

    function automatic logic [IDX_W-1:0] idx_wrap_inc(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(ENTRIES - 1)) ? '0 : i + 1'b1;
    endfunction

endpackage

// File: rtl/utlb_cam.sv
module utlb_cam
    import utlb_pkg::*;
(
    input  tlb_entry_t [ENTRIES-1:0] entries,
    input  logic [VPN_W-1:0]         vpn,
    output logic                     hit,
    output logic [PPN_W-1:0]         ppn,
    output logic [ATTR_W-1:0]        attr
);

    logic [ENTRIES-1:0] match;

    // One comparator per entry, all evaluated in parallel
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = entries[g].valid && (entries[g].vpn == vpn);
    end

    assign hit = |match;

    // AND-OR select: at most one entry matches since only misses install
    always_comb begin
        ppn  = '0;
        attr = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            ppn  = ppn  | (entries[i].ppn  & {PPN_W{match[i]}});
            attr = attr | (entries[i].attr & {ATTR_W{match[i]}});
        end
    end

endmodule

// File: rtl/utlb_victim.sv
module utlb_victim
    import utlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             write_en,
    input  repl_mode_e       mode,
    output logic [IDX_W-1:0] victim
);

    logic [IDX_W-1:0] ptr_q;
    logic [RNG_W-1:0] rng_q;
    logic [IDX_W-1:0] rand_idx;

    assign rand_idx = IDX_W'(rng_q % RNG_W'(ENTRIES));
    assign victim   = (mode == REPL_RANDOM) ? rand_idx : ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            rng_q <= RNG_SEED;
        end else if (write_en) begin
            if (mode == REPL_RANDOM) begin
                rng_q <= rng_step(rng_q);
            end else begin
                ptr_q <= idx_wrap_inc(ptr_q);
            end
        end
    end

endmodule

// File: rtl/utlb_ctrl.sv
module utlb_ctrl
    import utlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             cam_hit,
    input  logic             fill_valid,
    output logic             ready,
    output logic             req,
    output logic [VPN_W-1:0] req_vpn,
    output logic             install
);

    fill_state_e      state_q;
    logic [VPN_W-1:0] pend_q;

    assign ready   = (state_q == ST_IDLE);
    assign req     = (state_q == ST_WAIT);
    assign req_vpn = pend_q;
    assign install = (state_q == ST_WAIT) && fill_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (lk_valid && !cam_hit) begin
                    state_q <= ST_WAIT;
                    pend_q  <= lk_vpn;
                end
                ST_WAIT: if (fill_valid) begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/micro_tlb.sv
module micro_tlb
    import utlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_ready,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [ATTR_W-1:0] lk_attr,
    output logic              mt_req,
    output logic [VPN_W-1:0]  mt_vpn,
    input  logic              mt_fill_valid,
    input  logic [PPN_W-1:0]  mt_fill_ppn,
    input  logic [ATTR_W-1:0] mt_fill_attr,
    input  logic              flush,
    input  logic              repl_random
);

    tlb_entry_t [ENTRIES-1:0] entries_q;
    logic                     cam_hit;
    logic                     install;
    logic                     write_en;
    logic [IDX_W-1:0]         victim_idx;
    repl_mode_e               mode;

    assign mode     = repl_mode_e'(repl_random);
    assign write_en = install && !flush;

    utlb_cam u_cam (
        .entries (entries_q),
        .vpn     (lk_vpn),
        .hit     (cam_hit),
        .ppn     (lk_ppn),
        .attr    (lk_attr)
    );

    utlb_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .lk_valid   (lk_valid),
        .lk_vpn     (lk_vpn),
        .cam_hit    (cam_hit),
        .fill_valid (mt_fill_valid),
        .ready      (lk_ready),
        .req        (mt_req),
        .req_vpn    (mt_vpn),
        .install    (install)
    );

    utlb_victim u_victim (
        .clk      (clk),
        .rst      (rst),
        .write_en (write_en),
        .mode     (mode),
        .victim   (victim_idx)
    );

    assign lk_hit = lk_valid && lk_ready && cam_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            entries_q <= '0;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                entries_q[i].valid <= 1'b0;
            end
        end else if (write_en) begin
            entries_q[victim_idx] <= '{valid: 1'b1, vpn: mt_vpn,
                                       ppn: mt_fill_ppn, attr: mt_fill_attr};
        end
    end

endmodule

// File: rtl/micro_tlb_chk.sv
module micro_tlb_chk
    import utlb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             lk_ready,
    input logic             lk_hit,
    input logic             mt_req,
    input logic [VPN_W-1:0] mt_vpn,
    input logic             mt_fill_valid,
    input logic             flush,
    input logic [IDX_W-1:0] victim
);

    // R2
    hit_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_ready && lk_valid));

    // R3
    miss_raises_req_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready && !lk_hit) |=> (mt_req && !lk_ready));

    // R3
    req_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (mt_req && !mt_fill_valid) |=> (mt_req && $stable(mt_vpn)));

    // R4
    fill_release_chk: assert property (@(posedge clk) disable iff (rst)
        (mt_req && mt_fill_valid) |=> (lk_ready && !mt_req));

    // R5
    idle_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_ready && !lk_valid && mt_fill_valid) |=> (lk_ready && !mt_req));

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);

    // R9
    idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_ready && !lk_valid) |=> !mt_req);

    // R6
    victim_range_chk: assert property (@(posedge clk) disable iff (rst)
        victim < IDX_W'(ENTRIES));

endmodule

bind micro_tlb micro_tlb_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_valid      (lk_valid),
    .lk_ready      (lk_ready),
    .lk_hit        (lk_hit),
    .mt_req        (mt_req),
    .mt_vpn        (mt_vpn),
    .mt_fill_valid (mt_fill_valid),
    .flush         (flush),
    .victim        (victim_idx)
);

// File: tb/test_micro_tlb.sv
module test_micro_tlb;
    import utlb_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              lk_valid;
    logic [VPN_W-1:0]  lk_vpn;
    logic              lk_ready, lk_hit, mt_req;
    logic [PPN_W-1:0]  lk_ppn;
    logic [ATTR_W-1:0] lk_attr;
    logic [VPN_W-1:0]  mt_vpn;
    logic              mt_fill_valid;
    logic [PPN_W-1:0]  mt_fill_ppn;
    logic [ATTR_W-1:0] mt_fill_attr;
    logic              flush, repl_random;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model of cache contents and victim choice
    logic [VPN_W-1:0] m_vpn [ENTRIES];
    logic             m_val [ENTRIES];
    int               m_ptr;
    logic [15:0]      m_rng;

    always #4 clk = ~clk;

    micro_tlb i_micro_tlb (.*);

    // Phase-one stream: {expected hit, page}
    localparam int NVEC = 18;
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 20'h0A000}, {1'b0, 20'h0A001}, {1'b0, 20'h0A002}, {1'b0, 20'h0A003},
        {1'b0, 20'h0A004}, {1'b0, 20'h0A005}, {1'b0, 20'h0A006}, {1'b0, 20'h0A007},
        {1'b0, 20'h0A008}, {1'b0, 20'h0A009}, {1'b1, 20'h0A000}, {1'b1, 20'h0A005},
        {1'b0, 20'h0B000}, {1'b0, 20'h0A000}, {1'b0, 20'h0A001}, {1'b1, 20'h0A003},
        {1'b1, 20'h0A009}, {1'b1, 20'h0B000}
    };

    function automatic logic [PPN_W-1:0] ppn_of(input logic [VPN_W-1:0] v);
        return v ^ 20'h5A5A5;
    endfunction

    function automatic logic [ATTR_W-1:0] attr_of(input logic [VPN_W-1:0] v);
        return v[7:0] ^ 8'h3C;
    endfunction

    function automatic logic model_hit(input logic [VPN_W-1:0] v);
        for (int i = 0; i < ENTRIES; i++) if (m_val[i] && m_vpn[i] == v) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_install(input logic [VPN_W-1:0] v);
        int idx;
        if (repl_random) begin
            idx   = int'(m_rng % 16'd10);
            m_rng = m_rng[0] ? ((m_rng >> 1) ^ 16'hB400) : (m_rng >> 1);
        end else begin
            idx   = m_ptr;
            m_ptr = (m_ptr == ENTRIES - 1) ? 0 : m_ptr + 1;
        end
        m_vpn[idx] = v;
        m_val[idx] = 1'b1;
    endtask

    // Called just after a negedge; leaves the bench just after a negedge
    task automatic do_lookup(input logic [VPN_W-1:0] v, input logic exp_hit, input string req);
        lk_valid = 1'b1;
        lk_vpn   = v;
        #1;
        check({req, " ready"}, 32'(lk_ready), 32'd1);
        check({req, " hit"}, 32'(lk_hit), 32'(exp_hit));
        if (exp_hit) begin
            check("R2 ppn", 32'(lk_ppn), 32'(ppn_of(v)));
            check("R2 attr", 32'(lk_attr), 32'(attr_of(v)));
            @(negedge clk);
            lk_valid = 1'b0;
        end else begin
            @(negedge clk);
            lk_valid = 1'b0;
            #1;
            check("R3 req", 32'(mt_req), 32'd1);
            check("R3 vpn", 32'(mt_vpn), 32'(v));
            check("R3 not ready", 32'(lk_ready), 32'd0);
            @(negedge clk);
            @(negedge clk);
            #1;
            check("R3 req held", 32'(mt_req), 32'd1);
            mt_fill_valid = 1'b1;
            mt_fill_ppn   = ppn_of(v);
            mt_fill_attr  = attr_of(v);
            @(negedge clk);
            mt_fill_valid = 1'b0;
            model_install(v);
            #1;
            check("R4 ready", 32'(lk_ready), 32'd1);
            check("R4 req drop", 32'(mt_req), 32'd0);
            lk_valid = 1'b1;
            #1;
            check("R4 refill hit", 32'(lk_hit), 32'd1);
            check("R4 ppn", 32'(lk_ppn), 32'(ppn_of(v)));
            @(negedge clk);
            lk_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; lk_valid = 1'b0; lk_vpn = '0; mt_fill_valid = 1'b0;
        mt_fill_ppn = '0; mt_fill_attr = '0; flush = 1'b0; repl_random = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin m_val[i] = 1'b0; m_vpn[i] = '0; end
        m_ptr = 0;
        m_rng = 16'hACE1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 ready", 32'(lk_ready), 32'd1);
        check("R1 req", 32'(mt_req), 32'd0);
        check("R1 hit", 32'(lk_hit), 32'd0);

        // Table walk: R2 hits, R3/R4 misses, R6 rotating wrap (B0 evicts A0 in entry 0)
        for (int k = 0; k < NVEC; k++) begin
            do_lookup(VEC[k][19:0], VEC[k][20], "R6 table");
        end

        // R9: cached page with lk_valid low
        lk_vpn = 20'h0A009;
        #1;
        check("R9 no hit", 32'(lk_hit), 32'd0);
        @(negedge clk);
        #1;
        check("R9 no req", 32'(mt_req), 32'd0);

        // R5: stray fill while idle
        mt_fill_valid = 1'b1;
        mt_fill_ppn   = 20'hFFFFF;
        mt_fill_attr  = 8'hFF;
        @(negedge clk);
        mt_fill_valid = 1'b0;
        #1;
        check("R5 ready", 32'(lk_ready), 32'd1);
        check("R5 req", 32'(mt_req), 32'd0);
        do_lookup(20'h0A009, 1'b1, "R5 entry kept");
        do_lookup(20'h0A004, 1'b1, "R5 entry kept");

        // R8: flush, then every former page misses
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < ENTRIES; i++) m_val[i] = 1'b0;
        lk_vpn = 20'h0A005;
        lk_valid = 1'b1;
        #1;
        check("R8 flushed miss", 32'(lk_hit), 32'd0);
        lk_vpn = 20'h0B000;
        #1;
        check("R8 flushed miss", 32'(lk_hit), 32'd0);
        lk_valid = 1'b0;
        do_lookup(20'h0A003, 1'b0, "R8 after flush");

        // R7: random mode over more pages than fit, against the model
        repl_random = 1'b1;
        for (int k = 0; k < 14; k++) begin
            do_lookup(20'h0D000 + 20'(k), model_hit(20'h0D000 + 20'(k)), "R7 fill");
        end
        for (int k = 0; k < 14; k++) begin
            do_lookup(20'h0D000 + 20'(k), model_hit(20'h0D000 + 20'(k)), "R7 revisit");
        end

        // R6: back to rotating mode, pointer resumes where it stopped
        repl_random = 1'b0;
        for (int k = 0; k < 4; k++) begin
            do_lookup(20'h0E000 + 20'(k), model_hit(20'h0E000 + 20'(k)), "R6 resume");
        end
        for (int k = 0; k < 14; k++) begin
            do_lookup(20'h0D000 + 20'(k), model_hit(20'h0D000 + 20'(k)), "R6 evictions");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule